// File: doc/BRIEF.md
# Power Button and Supply-On Controller

This block turns a mechanical, active-low push-button and a few software strobes into the single supply-on output of a system. It tracks three power states: off, on and suspend. What a press does depends on that state and on whether the power-management mode is enabled. Without the mode, a press toggles the supply directly. With the mode, a press in the on state is reported to software as a management interrupt. Software then has a fixed interval to acknowledge it, which puts the system into suspend. If software stays silent, the supply is cut.

One interval counter serves two purposes. It times how long software takes to acknowledge the press, and it times how long the button is held. A hold that reaches the interval forces the supply off, whatever software does. Software can also cut the supply on its own through a request strobe. The button passes through a two-flop synchroniser, and press and release are detected as edges of the synchronised level. The interval is a cycle count, derived by default from the clock frequency and a number of seconds.

Top module: `pwrbtn_ctrl`

## Requirements
- R1: After reset, `supply_on` is 0, `pwr_state` is 2'b00, and `btn_status`, `irq_src` and `mgmt_irq` are all 0.
- R2: In the off state, a press (falling edge of `btn_n`) moves the block to on. No hold counting runs for that press, so holding the button longer than the interval leaves the system on.
- R3: In the on state with `pm_mode_en` low, a press moves the block to off.
- R4: In the on state with `pm_mode_en` high, a press leaves the state at on. It sets `btn_status` and `irq_src` and pulses `mgmt_irq` high for exactly one cycle.
- R5: While `btn_status` is set in the on state, a `sts_clr` strobe given before the interval expires moves the block to suspend. The same strobe clears `btn_status` and `irq_src`, and `supply_on` stays 1.
- R6: If `btn_status` is still set in the on state when the interval expires, the block goes to off and both status bits clear.
- R7: A press that begins in the on state with the mode enabled, and is held for the interval, forces off. This holds even if the state moved to suspend meanwhile. The later release, and any time spent still held, do not power the system back on. The next press powers it on.
- R8: In suspend, a press released before the interval moves the block to on on its release. While the button is held the state stays at suspend.
- R9: In suspend, a press held for the interval forces off.
- R10: A `sw_off_req` strobe moves the block from on or suspend to off. In off it has no effect.
- R11: A `sts_clr` strobe while `btn_status` is 0 leaves the state unchanged.
- R12: The state code on `pwr_state` is 2'b00 for off, 2'b01 for on and 2'b10 for suspend. `supply_on` is 1 exactly when the state is on or suspend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_n | input | 1 | Asynchronous push-button, low while pressed |
| pm_mode_en | input | 1 | Power-management mode enable |
| sw_off_req | input | 1 | Software power-off strobe |
| sts_clr | input | 1 | Software write strobe that clears the status bits |
| supply_on | output | 1 | Supply enable |
| mgmt_irq | output | 1 | One-cycle management interrupt pulse |
| btn_status | output | 1 | Button-pressed status bit |
| irq_src | output | 1 | Interrupt-source bit |
| pwr_state | output | 2 | Power state code |

## Verification
The bench builds the block with `TIMEOUT_CYC` set to 24 in place of the multi-second default. This brings both the acknowledge deadline and the long-hold limit within a few dozen cycles of the press. Short presses of six cycles and holds of forty cycles therefore fall clearly on either side of the limit. Acknowledges given about ten cycles after a press land inside the window. As a result, the guard expiry, the forced-off hold, the suspend wake-up and the lockout after a forced power-off can all be reached in one short run.

// File: rtl/pwrbtn_pkg.sv
// Package: shared state encoding for the power button controller.
// Assumes: the state code is exported as-is on the top-level pwr_state port.
package pwrbtn_pkg;
    typedef enum logic [1:0] {
        PB_OFF  = 2'b00,
        PB_ON   = 2'b01,
        PB_SUSP = 2'b10
    } pb_state_e;
endpackage

// File: rtl/pwrbtn_sync.sv
// Module: synchronises the asynchronous active-low button and produces
// press (falling) and release (rising) pulses, plus the pressed level.
// Assumes: the button idles high; every flop resets to the released level.
module pwrbtn_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic pressed,
    output logic btn_fall,
    output logic btn_rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw button level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], btn_n};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign pressed  = ~chain_q[STAGES-1];
    assign btn_fall = prev_q & ~chain_q[STAGES-1];
    assign btn_rise = ~prev_q & chain_q[STAGES-1];

    // R2: a press pulse never lasts two cycles.
    a_r2_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        btn_fall |=> !btn_fall);
endmodule

// File: rtl/pwrbtn_interval.sv
// Module: interval counter that counts cycles while run is high and
// flags expiry once LIMIT cycles have been counted; restart zeroes it.
// Assumes: LIMIT >= 1; the count saturates at LIMIT.
module pwrbtn_interval #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    assign expired = (cnt_q == W'(LIMIT));

    // Advance the count while running, hold at the limit, zero on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: expiry is only ever reached after a cycle in which the counter ran.
    a_r6_expiry_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(run));
endmodule

// File: rtl/pwrbtn_fsm.sv
// Module: power state machine. Decides on, off and suspend from button
// edges, the interval expiries and the software strobes.
// Assumes: press and release pulses never coincide. Priority, highest
// first: software off, hold expiry, guard expiry, then button and
// acknowledge events.
module pwrbtn_fsm
    import pwrbtn_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      btn_fall,
    input  logic      btn_rise,
    input  logic      pm_mode_en,
    input  logic      sw_off_req,
    input  logic      sts_clr,
    input  logic      hold_exp,
    input  logic      guard_exp,
    output pb_state_e state,
    output logic      status,
    output logic      src,
    output logic      irq_pulse,
    output logic      hold_owned
);
    pb_state_e st_q, st_d;
    logic status_q, status_d, src_q, src_d, irq_q, irq_d;
    logic own_q, own_d, insusp_q, insusp_d;

    // Compute the next state and the status bits from this cycle's events.
    always_comb begin
        st_d     = st_q;
        status_d = status_q;
        src_d    = src_q;
        own_d    = own_q;
        insusp_d = insusp_q;
        irq_d    = 1'b0;
        if (btn_rise) begin
            own_d    = 1'b0;
            insusp_d = 1'b0;
        end
        if (st_q == PB_OFF) begin
            if (btn_fall) st_d = PB_ON;
            own_d    = 1'b0;
            insusp_d = 1'b0;
        end else if (sw_off_req || (own_q && hold_exp) ||
                     (st_q == PB_ON && status_q && guard_exp)) begin
            st_d     = PB_OFF;
            status_d = 1'b0;
            src_d    = 1'b0;
            own_d    = 1'b0;
            insusp_d = 1'b0;
        end else begin
            case (st_q)
                PB_ON: begin
                    if (btn_fall) begin
                        if (!pm_mode_en) begin
                            st_d = PB_OFF;
                        end else begin
                            status_d = 1'b1;
                            src_d    = 1'b1;
                            irq_d    = 1'b1;
                            own_d    = 1'b1;
                            insusp_d = 1'b0;
                        end
                    end else if (sts_clr) begin
                        status_d = 1'b0;
                        src_d    = 1'b0;
                        if (status_q) st_d = PB_SUSP;
                    end
                end
                PB_SUSP: begin
                    if (btn_fall) begin
                        own_d    = 1'b1;
                        insusp_d = 1'b1;
                    end else if (btn_rise && insusp_q) begin
                        st_d = PB_ON;
                    end
                end
                default: st_d = PB_OFF;
            endcase
        end
    end

    // Register the state, the status bits and the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= PB_OFF;
            status_q <= 1'b0;
            src_q    <= 1'b0;
            irq_q    <= 1'b0;
            own_q    <= 1'b0;
            insusp_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            status_q <= status_d;
            src_q    <= src_d;
            irq_q    <= irq_d;
            own_q    <= own_d;
            insusp_q <= insusp_d;
        end
    end

    assign state      = st_q;
    assign status     = status_q;
    assign src        = src_q;
    assign irq_pulse  = irq_q;
    assign hold_owned = own_q;

    // R2: a press while off powers the system on.
    a_r2_off_press_on: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PB_OFF && btn_fall) |=> (st_q == PB_ON));
    // R3: without the mode, a press while on powers off.
    a_r3_plain_press_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PB_ON && !pm_mode_en && btn_fall) |=> (st_q == PB_OFF));
    // R4: with the mode, a press while on reports to software and stays on.
    a_r4_press_reports: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PB_ON && pm_mode_en && btn_fall && !sw_off_req &&
         !(status_q && guard_exp) && !(own_q && hold_exp))
        |=> (st_q == PB_ON && status_q && src_q && irq_q));
    // R10: a software off request ends in off from any state.
    a_r10_sw_off: assert property (@(posedge clk) disable iff (!rst_n)
        sw_off_req |=> (st_q == PB_OFF));
    // R4: the interrupt is a single-cycle pulse.
    a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
endmodule

// File: rtl/pwrbtn_ctrl.sv
// Module: top of the power button controller. Connects the synchroniser,
// the hold and guard interval counters and the state machine.
// Assumes: one interval (TIMEOUT_CYC) serves both the acknowledge
// deadline and the long-hold limit.
module pwrbtn_ctrl
    import pwrbtn_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 250_000_000,
    parameter int unsigned TIMEOUT_SEC = 4,
    parameter int unsigned TIMEOUT_CYC = CLK_HZ * TIMEOUT_SEC,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       btn_n,
    input  logic       pm_mode_en,
    input  logic       sw_off_req,
    input  logic       sts_clr,
    output logic       supply_on,
    output logic       mgmt_irq,
    output logic       btn_status,
    output logic       irq_src,
    output logic [1:0] pwr_state
);
    logic      pressed, btn_fall, btn_rise;
    logic      hold_exp, guard_exp, hold_owned;
    pb_state_e state;

    pwrbtn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn_n    (btn_n),
        .pressed  (pressed),
        .btn_fall (btn_fall),
        .btn_rise (btn_rise)
    );

    pwrbtn_interval #(.LIMIT(TIMEOUT_CYC)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (hold_owned && pressed),
        .restart (btn_fall),
        .expired (hold_exp)
    );

    pwrbtn_interval #(.LIMIT(TIMEOUT_CYC)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (btn_status && state == PB_ON),
        .restart (!btn_status),
        .expired (guard_exp)
    );

    pwrbtn_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .btn_fall   (btn_fall),
        .btn_rise   (btn_rise),
        .pm_mode_en (pm_mode_en),
        .sw_off_req (sw_off_req),
        .sts_clr    (sts_clr),
        .hold_exp   (hold_exp),
        .guard_exp  (guard_exp),
        .state      (state),
        .status     (btn_status),
        .src        (irq_src),
        .irq_pulse  (mgmt_irq),
        .hold_owned (hold_owned)
    );

    assign supply_on = (state != PB_OFF);
    assign pwr_state = state;

    // R12: the supply is enabled exactly in on and suspend.
    a_r12_supply_state: assert property (@(posedge clk) disable iff (!rst_n)
        supply_on == (pwr_state == 2'b01 || pwr_state == 2'b10));
endmodule

// File: tb/pwrbtn_ctrl_tb.sv
// Bench: scoreboard. Driver tasks push expected outputs into a queue,
// and a monitor pops and compares them on the next falling clock edge.
module pwrbtn_ctrl_tb;
    localparam int TMO = 24;

    logic clk = 1'b0, rst_n = 1'b0;
    logic btn_n = 1'b1, pm_mode_en = 1'b0, sw_off_req = 1'b0, sts_clr = 1'b0;
    logic supply_on, mgmt_irq, btn_status, irq_src;
    logic [1:0] pwr_state;

    typedef struct {
        logic [1:0] st;
        logic       sup;
        logic       bs;
        logic       src;
        int         pulses;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0, errors = 0, pulses_seen = 0, exp_pulses = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    pwrbtn_ctrl #(.TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .pm_mode_en(pm_mode_en),
        .sw_off_req(sw_off_req), .sts_clr(sts_clr), .supply_on(supply_on),
        .mgmt_irq(mgmt_irq), .btn_status(btn_status), .irq_src(irq_src),
        .pwr_state(pwr_state)
    );

    // Monitor: count interrupt pulses, then compare any queued expectations.
    always @(negedge clk) begin
        if (rst_n && mgmt_irq) pulses_seen++;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (pwr_state !== e.st || supply_on !== e.sup || btn_status !== e.bs ||
                irq_src !== e.src || pulses_seen != e.pulses) begin
                errors++;
                $display("FAIL %s: actual st=%b sup=%b bs=%b src=%b irqs=%0d expected st=%b sup=%b bs=%b src=%b irqs=%0d",
                         e.tag, pwr_state, supply_on, btn_status, irq_src, pulses_seen,
                         e.st, e.sup, e.bs, e.src, e.pulses);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic [1:0] st, input logic bs, input logic src,
                              input string tag);
        exp_t e;
        e.st = st; e.sup = (st != 2'b00); e.bs = bs; e.src = src;
        e.pulses = exp_pulses; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic press(input int hold);
        btn_n = 1'b0;
        cyc(hold);
        btn_n = 1'b1;
        cyc(4);
    endtask

    task automatic strobe_clr();
        sts_clr = 1'b1; cyc(1); sts_clr = 1'b0; cyc(2);
    endtask

    task automatic strobe_off();
        sw_off_req = 1'b1; cyc(1); sw_off_req = 1'b0; cyc(2);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    // Driver: stimulus sequence with expectations.
    initial begin
        cyc(3);
        expect_out(2'b00, 0, 0, "R1 reset state");
        rst_n = 1'b1;
        cyc(2);
        expect_out(2'b00, 0, 0, "R12 off code after reset");

        btn_n = 1'b0; cyc(4);
        expect_out(2'b01, 0, 0, "R2 press from off powers on");
        cyc(40);
        expect_out(2'b01, 0, 0, "R2 long hold from off stays on");
        btn_n = 1'b1; cyc(4);
        expect_out(2'b01, 0, 0, "R12 on code after release");

        press(6);
        expect_out(2'b00, 0, 0, "R3 plain-mode press powers off");

        press(6);
        expect_out(2'b01, 0, 0, "R2 press powers on again");
        pm_mode_en = 1'b1;
        press(6);
        exp_pulses++;
        expect_out(2'b01, 1, 1, "R4 mode press sets status and pulses irq");
        strobe_clr();
        expect_out(2'b10, 0, 0, "R5 acknowledge enters suspend");

        btn_n = 1'b0; cyc(6);
        expect_out(2'b10, 0, 0, "R8 held press keeps suspend");
        btn_n = 1'b1; cyc(4);
        expect_out(2'b01, 0, 0, "R8 short press wakes on release");

        press(6);
        exp_pulses++;
        expect_out(2'b01, 1, 1, "R4 second report");
        cyc(40);
        expect_out(2'b00, 0, 0, "R6 unanswered report powers off");

        press(6);
        expect_out(2'b01, 0, 0, "R2 power on before hold test");
        btn_n = 1'b0; cyc(8);
        exp_pulses++;
        strobe_clr();
        expect_out(2'b10, 0, 0, "R5 acknowledge while still held");
        cyc(35);
        expect_out(2'b00, 0, 0, "R7 long hold forces off");
        btn_n = 1'b1; cyc(10);
        expect_out(2'b00, 0, 0, "R7 release after forced off ignored");
        press(6);
        expect_out(2'b01, 0, 0, "R7 next press powers on");

        press(6);
        exp_pulses++;
        strobe_clr();
        expect_out(2'b10, 0, 0, "R5 suspend before long hold");
        btn_n = 1'b0; cyc(40);
        expect_out(2'b00, 0, 0, "R9 long hold in suspend powers off");
        btn_n = 1'b1; cyc(6);
        expect_out(2'b00, 0, 0, "R9 stays off after release");

        press(6);
        strobe_clr();
        expect_out(2'b01, 0, 0, "R11 acknowledge without status ignored");
        strobe_off();
        expect_out(2'b00, 0, 0, "R10 software off from on");
        strobe_off();
        expect_out(2'b00, 0, 0, "R10 software off while off ignored");

        press(6);
        press(6);
        exp_pulses++;
        strobe_clr();
        expect_out(2'b10, 0, 0, "R5 suspend before software off");
        strobe_off();
        expect_out(2'b00, 0, 0, "R10 software off from suspend");

        cyc(2);
        finish_run();
    end
endmodule